// File: doc/BRIEF.md
# Single-Wire Temperature Sensor Master

This block is the master side of a single-wire, open-drain bus that runs one temperature sensor. It builds the four kinds of bit-level time slot (bus reset with presence detect, write-one, write-zero, read) from a shared microsecond tick. It chains those slots into a complete measurement. The measurement starts with a reset and presence check, then sends the addressing command and the convert command. It waits for the conversion to finish, resets and addresses the sensor again, and sends the read command. It then reads a 16-bit word least significant bit first and closes with a last reset and presence check.

The pad is modelled as two signals. `line_pull` set to 1 drives the wire low. `line_in` is the level sensed on the wire. A missing presence pulse aborts the measurement and raises an error flag. A clean finish delivers the word on `temp_word` with a one-cycle `temp_valid` strobe. A start request held high runs measurements back to back.

Top module: `owm_temp_master`

## Requirements
- R1: After reset, `line_pull`, `busy`, `temp_valid` and `presence_err` are 0 and `temp_word` is 0. `line_pull` is never 1 while `busy` is 0.
- R2: A bus reset holds the line low for RST_LOW_US ticks and then releases it. Each measurement issues exactly three bus resets.
- R3: The master samples the line RST_SAMPLE_US ticks after a reset releases it, and a low level counts as presence. If presence is missing at any of the three resets, `presence_err` goes to 1, `busy` drops, no `temp_valid` follows and no further slot is driven. `presence_err` clears when the next start is accepted.
- R4: A write-0 slot holds the line low for WR0_LOW_US ticks and a write-1 slot for WR1_LOW_US ticks. Consecutive bit slots start BIT_SLOT_US ticks apart, with at most two extra ticks of handshake.
- R5: After the first presence, the byte 0xCC (addressing) and then the byte 0x44 (convert) are sent, each least significant bit first.
- R6: After the convert command the line stays released for CONV_WAIT_US ticks before the second bus reset.
- R7: After the second presence, the byte 0xCC and then the byte 0xBE (read) are sent, each least significant bit first.
- R8: Next come 16 read slots, each pulling the line low for RD_LOW_US ticks and sampling it RD_SAMPLE_US ticks after the slot starts. The first bit read becomes bit 0 of `temp_word` and the last becomes bit 15.
- R9: After the third reset finds presence, `temp_valid` pulses for exactly one cycle with the new `temp_word`, and `busy` is 0 in that same cycle.
- R10: `start` is ignored while `busy` is 1. A `start` held at 1 across the end of a measurement launches the next one at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| start | input | 1 | Request a measurement |
| line_in | input | 1 | Sensed level of the bus wire |
| line_pull | output | 1 | 1 drives the wire low, 0 releases it |
| busy | output | 1 | Measurement in progress |
| temp_word | output | 16 | Last completed 16-bit readout |
| temp_valid | output | 1 | One-cycle strobe marking a new `temp_word` |
| presence_err | output | 1 | Last measurement aborted for a missing presence pulse |

## Verification
The embedded properties check the handshake between sequencer and slot timer on every cycle. A slot request holds steady until it is accepted, a slot ends only after running, and the wire stays untouched during the conversion wait. They also check that the valid strobe lasts one cycle with `busy` low, that an error rise comes with `busy` low, and that `busy` rises only on a request. Only the bench's sensor model can show the protocol as seen on the wire. That covers pulse widths and slot spacing measured in ticks, the command bytes decoded back from the pulse widths, the bit order of the returned word, the length of the conversion wait, and the abort taken at each of the three resets.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [1:0] {
        SLOT_RESET = 2'd0,
        SLOT_WR0   = 2'd1,
        SLOT_WR1   = 2'd2,
        SLOT_READ  = 2'd3
    } slot_kind_e;

    typedef struct packed {
        logic       valid;
        slot_kind_e kind;
    } slot_req_t;

    typedef struct packed {
        logic done;
        logic level;
    } slot_rsp_t;

    typedef enum logic [1:0] {
        ROUND_CONVERT = 2'd0,
        ROUND_FETCH   = 2'd1,
        ROUND_CLOSE   = 2'd2
    } round_e;

    localparam logic [7:0] CMD_ADDR_ALL = 8'hCC;
    localparam logic [7:0] CMD_CONVERT  = 8'h44;
    localparam logic [7:0] CMD_FETCH    = 8'hBE;

    function automatic logic [7:0] cmd_byte(input round_e rnd, input logic second);
        if (!second)
            return CMD_ADDR_ALL;
        else if (rnd == ROUND_CONVERT)
            return CMD_CONVERT;
        else
            return CMD_FETCH;
    endfunction

endpackage

// File: rtl/owm_slot_timer.sv
module owm_slot_timer
    import owm_pkg::*;
#(
    parameter int RST_LOW_US    = 480,
    parameter int RST_SAMPLE_US = 70,
    parameter int RST_SLOT_US   = 960,
    parameter int BIT_SLOT_US   = 70,
    parameter int WR0_LOW_US    = 60,
    parameter int WR1_LOW_US    = 6,
    parameter int RD_LOW_US     = 2,
    parameter int RD_SAMPLE_US  = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      us_tick,
    input  logic      line_in,
    input  slot_req_t req,
    output logic      slot_busy,
    output slot_rsp_t rsp,
    output logic      line_pull
);
    localparam int LONGEST = (RST_SLOT_US > BIT_SLOT_US) ? RST_SLOT_US : BIT_SLOT_US;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic             active;
    slot_kind_e       kind_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] slot_len;
    logic [CNT_W-1:0] sample_pt;
    logic             done_q;
    logic             level_q;

    always_comb begin
        case (kind_q)
            SLOT_RESET: begin
                low_len   = CNT_W'(RST_LOW_US);
                slot_len  = CNT_W'(RST_SLOT_US);
                sample_pt = CNT_W'(RST_LOW_US + RST_SAMPLE_US);
            end
            SLOT_WR0: begin
                low_len   = CNT_W'(WR0_LOW_US);
                slot_len  = CNT_W'(BIT_SLOT_US);
                sample_pt = CNT_W'(RD_SAMPLE_US);
            end
            SLOT_WR1: begin
                low_len   = CNT_W'(WR1_LOW_US);
                slot_len  = CNT_W'(BIT_SLOT_US);
                sample_pt = CNT_W'(RD_SAMPLE_US);
            end
            default: begin
                low_len   = CNT_W'(RD_LOW_US);
                slot_len  = CNT_W'(BIT_SLOT_US);
                sample_pt = CNT_W'(RD_SAMPLE_US);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            kind_q  <= SLOT_RESET;
            cnt     <= '0;
            done_q  <= 1'b0;
            level_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (req.valid) begin
                    active <= 1'b1;
                    kind_q <= req.kind;
                    cnt    <= '0;
                end
            end else if (us_tick) begin
                if (cnt == sample_pt)
                    level_q <= line_in;
                if (cnt == slot_len - 1'b1) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign slot_busy = active;
    assign line_pull = active && (cnt < low_len);
    assign rsp.done  = done_q;
    assign rsp.level = level_q;

    // R4
    slot_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!active && $past(active)));

    // R2
    slot_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !$past(active)) |-> $past(req.valid));

endmodule

// File: rtl/owm_sequencer.sv
module owm_sequencer
    import owm_pkg::*;
#(
    parameter int CONV_WAIT_US = 750000,
    parameter int DATA_BITS    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 us_tick,
    input  logic                 start,
    input  logic                 slot_busy,
    input  slot_rsp_t            rsp,
    output slot_req_t            req,
    output logic                 busy,
    output logic [DATA_BITS-1:0] temp_word,
    output logic                 temp_valid,
    output logic                 presence_err
);
    localparam int WAIT_W = $clog2(CONV_WAIT_US + 1);
    localparam int IDX_W  = $clog2((DATA_BITS > 8) ? DATA_BITS : 8);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_GO,
        ST_RST_WAIT,
        ST_TX_GO,
        ST_TX_WAIT,
        ST_CONV,
        ST_RX_GO,
        ST_RX_WAIT
    } seq_state_e;

    seq_state_e           state;
    round_e               rnd;
    logic                 second;
    logic [IDX_W-1:0]     bit_idx;
    logic [WAIT_W-1:0]    wait_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic [7:0]           cur_byte;

    assign cur_byte = cmd_byte(rnd, second);

    always_comb begin
        req.valid = 1'b0;
        req.kind  = SLOT_RESET;
        case (state)
            ST_RST_GO: req.valid = 1'b1;
            ST_TX_GO: begin
                req.valid = 1'b1;
                req.kind  = cur_byte[bit_idx[2:0]] ? SLOT_WR1 : SLOT_WR0;
            end
            ST_RX_GO: begin
                req.valid = 1'b1;
                req.kind  = SLOT_READ;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            rnd          <= ROUND_CONVERT;
            second       <= 1'b0;
            bit_idx      <= '0;
            wait_cnt     <= '0;
            shreg        <= '0;
            busy         <= 1'b0;
            temp_word    <= '0;
            temp_valid   <= 1'b0;
            presence_err <= 1'b0;
        end else begin
            temp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        busy         <= 1'b1;
                        presence_err <= 1'b0;
                        rnd          <= ROUND_CONVERT;
                        state        <= ST_RST_GO;
                    end
                end
                ST_RST_GO: begin
                    if (!slot_busy)
                        state <= ST_RST_WAIT;
                end
                ST_RST_WAIT: begin
                    if (rsp.done) begin
                        if (rsp.level) begin
                            presence_err <= 1'b1;
                            busy         <= 1'b0;
                            state        <= ST_IDLE;
                        end else if (rnd == ROUND_CLOSE) begin
                            temp_word  <= shreg;
                            temp_valid <= 1'b1;
                            busy       <= 1'b0;
                            state      <= ST_IDLE;
                        end else begin
                            second  <= 1'b0;
                            bit_idx <= '0;
                            state   <= ST_TX_GO;
                        end
                    end
                end
                ST_TX_GO: begin
                    if (!slot_busy)
                        state <= ST_TX_WAIT;
                end
                ST_TX_WAIT: begin
                    if (rsp.done) begin
                        if (bit_idx == IDX_W'(7)) begin
                            bit_idx <= '0;
                            if (!second) begin
                                second <= 1'b1;
                                state  <= ST_TX_GO;
                            end else if (rnd == ROUND_CONVERT) begin
                                wait_cnt <= '0;
                                state    <= ST_CONV;
                            end else begin
                                state <= ST_RX_GO;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_TX_GO;
                        end
                    end
                end
                ST_CONV: begin
                    if (us_tick) begin
                        if (wait_cnt == WAIT_W'(CONV_WAIT_US - 1)) begin
                            rnd   <= ROUND_FETCH;
                            state <= ST_RST_GO;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                        end
                    end
                end
                ST_RX_GO: begin
                    if (!slot_busy)
                        state <= ST_RX_WAIT;
                end
                ST_RX_WAIT: begin
                    if (rsp.done) begin
                        shreg <= {rsp.level, shreg[DATA_BITS-1:1]};
                        if (bit_idx == IDX_W'(DATA_BITS - 1)) begin
                            bit_idx <= '0;
                            rnd     <= ROUND_CLOSE;
                            state   <= ST_RST_GO;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_RX_GO;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.valid && slot_busy) |=> (req.valid && $stable(req.kind)));

    // R6
    conv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV) |-> !slot_busy);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        temp_valid |=> !temp_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        temp_valid |-> (!busy && !presence_err));

    // R3
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(presence_err) |-> !busy);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/owm_temp_master.sv
module owm_temp_master
    import owm_pkg::*;
#(
    parameter int RST_LOW_US    = 480,
    parameter int RST_SAMPLE_US = 70,
    parameter int RST_SLOT_US   = 960,
    parameter int BIT_SLOT_US   = 70,
    parameter int WR0_LOW_US    = 60,
    parameter int WR1_LOW_US    = 6,
    parameter int RD_LOW_US     = 2,
    parameter int RD_SAMPLE_US  = 15,
    parameter int CONV_WAIT_US  = 750000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        us_tick,
    input  logic        start,
    input  logic        line_in,
    output logic        line_pull,
    output logic        busy,
    output logic [15:0] temp_word,
    output logic        temp_valid,
    output logic        presence_err
);
    slot_req_t req;
    slot_rsp_t rsp;
    logic      slot_busy;

    owm_sequencer #(
        .CONV_WAIT_US(CONV_WAIT_US),
        .DATA_BITS   (16)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .us_tick     (us_tick),
        .start       (start),
        .slot_busy   (slot_busy),
        .rsp         (rsp),
        .req         (req),
        .busy        (busy),
        .temp_word   (temp_word),
        .temp_valid  (temp_valid),
        .presence_err(presence_err)
    );

    owm_slot_timer #(
        .RST_LOW_US   (RST_LOW_US),
        .RST_SAMPLE_US(RST_SAMPLE_US),
        .RST_SLOT_US  (RST_SLOT_US),
        .BIT_SLOT_US  (BIT_SLOT_US),
        .WR0_LOW_US   (WR0_LOW_US),
        .WR1_LOW_US   (WR1_LOW_US),
        .RD_LOW_US    (RD_LOW_US),
        .RD_SAMPLE_US (RD_SAMPLE_US)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .us_tick  (us_tick),
        .line_in  (line_in),
        .req      (req),
        .slot_busy(slot_busy),
        .rsp      (rsp),
        .line_pull(line_pull)
    );

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_pull);

endmodule

// File: tb/owm_temp_master_test.sv
`timescale 1ns/1ps
module owm_temp_master_test;
    localparam int RST_LOW  = 48;
    localparam int RST_SMP  = 7;
    localparam int RST_SLOT = 96;
    localparam int BIT_SLOT = 10;
    localparam int WR0_LOW  = 6;
    localparam int WR1_LOW  = 1;
    localparam int RD_LOW   = 1;
    localparam int RD_SMP   = 3;
    localparam int CONV     = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        start = 1'b0;
    logic        line_in;
    logic        line_pull;
    logic        busy;
    logic [15:0] temp_word;
    logic        temp_valid;
    logic        presence_err;

    logic        sensor_low = 1'b0;
    assign line_in = !(line_pull || sensor_low);

    always #2.5 clk = ~clk;

    owm_temp_master #(
        .RST_LOW_US(RST_LOW), .RST_SAMPLE_US(RST_SMP), .RST_SLOT_US(RST_SLOT),
        .BIT_SLOT_US(BIT_SLOT), .WR0_LOW_US(WR0_LOW), .WR1_LOW_US(WR1_LOW),
        .RD_LOW_US(RD_LOW), .RD_SAMPLE_US(RD_SMP), .CONV_WAIT_US(CONV)
    ) uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .start(start),
        .line_in(line_in), .line_pull(line_pull), .busy(busy),
        .temp_word(temp_word), .temp_valid(temp_valid), .presence_err(presence_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [16:0] exp_q[$];
    logic [15:0] sensor_word = '0;
    int          absent_idx = 0;

    int  us_now = 0;
    bit  tick_phase = 1'b0;
    bit  oe_prev = 1'b0;
    bit  busy_prev = 1'b0;
    int  rise_us = 0;
    int  last_bit_rise = 0;
    int  rst_idx = 0;
    int  bitcnt = 0;
    int  sl_from = 0;
    int  sl_to = 0;
    logic [7:0] rx_byte = '0;
    int  idle_drive = 0;
    int  valid_count = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic pop_cmp(input logic [16:0] got, input string tag);
        logic [16:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, tag, int'(got), 0);
        end else begin
            e = exp_q.pop_front();
            check(got == e, tag, int'(got), int'(e));
        end
    endtask

    // monitor, sensor model and tick source, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (line_pull && !busy) idle_drive++;
                if (busy && !busy_prev) begin
                    rst_idx = 0;
                    bitcnt  = 0;
                end
                if (line_pull && !oe_prev) begin
                    rise_us = us_now;
                    if (rst_idx == 2 && bitcnt >= 16 && !sensor_word[bitcnt-16]) begin
                        sl_from = us_now;
                        sl_to   = us_now + 6;
                    end
                end
                if (!line_pull && oe_prev) begin
                    int dur;
                    dur = us_now - rise_us;
                    if (dur >= 40) begin
                        // R2 reset low width
                        check(dur >= RST_LOW - 1 && dur <= RST_LOW + 1, "R2 reset low", dur, RST_LOW);
                        rst_idx++;
                        if (rst_idx == 2) begin
                            // R6 conversion wait
                            check((rise_us - last_bit_rise) >= BIT_SLOT + CONV &&
                                  (rise_us - last_bit_rise) <= BIT_SLOT + CONV + 3,
                                  "R6 conv wait", rise_us - last_bit_rise, BIT_SLOT + CONV);
                        end
                        bitcnt = 0;
                        if (rst_idx != absent_idx) begin
                            sl_from = us_now + 2;
                            sl_to   = us_now + 12;
                        end
                    end else begin
                        if (bitcnt > 0)
                            // R4 slot spacing
                            check((rise_us - last_bit_rise) >= BIT_SLOT &&
                                  (rise_us - last_bit_rise) <= BIT_SLOT + 2,
                                  "R4 slot spacing", rise_us - last_bit_rise, BIT_SLOT);
                        last_bit_rise = rise_us;
                        if (rst_idx == 2 && bitcnt >= 16) begin
                            // R8 read slot low width
                            check(dur <= RD_LOW + 1, "R8 read low", dur, RD_LOW);
                        end else begin
                            logic b;
                            if (dur <= WR1_LOW + 1) b = 1'b1;
                            else begin
                                b = 1'b0;
                                // R4 write-0 width
                                check(dur >= WR0_LOW - 1 && dur <= WR0_LOW + 1, "R4 wr0 low", dur, WR0_LOW);
                            end
                            rx_byte = {b, rx_byte[7:1]};
                            if (bitcnt == 7 || bitcnt == 15)
                                pop_cmp({1'b0, 8'h00, rx_byte}, (rst_idx == 1) ? "R5 cmd byte" : "R7 cmd byte");
                        end
                        bitcnt++;
                    end
                end
                if (temp_valid) begin
                    valid_count++;
                    // R9 strobe after third presence
                    check(!busy && rst_idx == 3, "R9 valid timing", rst_idx, 3);
                    pop_cmp({1'b1, temp_word}, "R8 temp word");
                end
                oe_prev   = line_pull;
                busy_prev = busy;
            end
            sensor_low = (us_now >= sl_from) && (us_now < sl_to);
            tick_phase = !tick_phase;
            us_tick <= tick_phase;
            if (tick_phase) us_now++;
        end
    end

    task automatic push_expect(input logic [15:0] w, input int absent);
        if (absent != 1) begin
            exp_q.push_back({1'b0, 8'h00, 8'hCC});
            exp_q.push_back({1'b0, 8'h00, 8'h44});
        end
        if (absent == 0 || absent == 3) begin
            exp_q.push_back({1'b0, 8'h00, 8'hCC});
            exp_q.push_back({1'b0, 8'h00, 8'hBE});
        end
        if (absent == 0)
            exp_q.push_back({1'b1, w});
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_measure(input logic [15:0] w, input int absent, input string tag);
        sensor_word = w;
        absent_idx  = absent;
        push_expect(w, absent);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        wait_idle();
        repeat (10) @(negedge clk);
        check(presence_err == (absent != 0), tag, int'(presence_err), int'(absent != 0));
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(line_pull == 1'b0 && busy == 1'b0 && temp_valid == 1'b0 &&
              presence_err == 1'b0 && temp_word == 16'h0, "R1 reset state",
              {line_pull, busy, temp_valid, presence_err}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        run_measure(16'h0191, 0, "R5 R7 R8 R9 normal");
        check(temp_word == 16'h0191, "R8 word held", temp_word, 16'h0191);
        run_measure(16'hFE6F, 0, "R8 negative pattern");
        run_measure(16'h8001, 0, "R8 edge bits");

        // R3 presence missing at each reset
        run_measure(16'h1234, 1, "R3 absent first");
        check(valid_count == 3, "R3 no valid after abort", valid_count, 3);
        run_measure(16'h1234, 2, "R3 absent second");
        run_measure(16'h1234, 3, "R3 absent third");
        check(valid_count == 3, "R3 no valid after abort", valid_count, 3);
        run_measure(16'h0550, 0, "R3 error cleared");

        // R10 start ignored while busy
        sensor_word = 16'hA5C3;
        absent_idx  = 0;
        push_expect(16'hA5C3, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (400) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R10 start ignored", busy, 0);
        check(exp_q.size() == 0 && temp_word == 16'hA5C3, "R10 single result", temp_word, 16'hA5C3);
        exp_q.delete();

        // R10 held start repeats
        sensor_word = 16'h3C3C;
        push_expect(16'h3C3C, 0);
        push_expect(16'h3C3C, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        wait_idle();
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 held start repeats", busy, 1);
        start = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R10 two results", exp_q.size(), 0);
        check(valid_count == 7, "R9 valid count", valid_count, 7);
        // R1 line released while idle
        check(idle_drive == 0, "R1 idle release", idle_drive, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule